// File: doc/BRIEF.md
# Switch Override and Board Reset Sequencer

This block is a byte-wide register slave for a board control device. Eight groups of eight physical configuration switches enter through a two-stage synchronizer. Software may override any single switch bit. Each group has a shadow byte that holds the replacement values and a mask byte that selects, bit by bit, whether the shadow bit or the synchronized switch bit is the effective value. The bus is a simple synchronous port: one write strobe, an 8-bit address, 8-bit write data and a combinational read data path.

Board reset can start in two ways. Any write to the hard reset address starts a reset that uses the raw synchronized switches and ignores every mask bit. A 0-to-1 transition of bit 0 in the sequencer control register starts a reset that uses the effective, overridden values. In both cases the chosen 64-bit set is latched onto the configuration output. The board reset output is then held for a parameterised number of cycles and released. The block also holds a 24-bit clock frequency word in three bytes, together with an enable bit that gates the word onto the clock configuration output. All software-visible state survives both kinds of board reset, so an override can take effect through the reset that requests it.

Address map: 0x00 hard reset trigger (reads 0); 0x01 sequencer control, bit 0; 0x02 clock enable, bit 0; 0x04, 0x05 and 0x06 clock word bytes, with 0x04 the most significant; 0x10+2g shadow byte of group g; 0x11+2g mask byte of group g. Unmapped addresses read 0. Group g drives bits [8g+7:8g] of the switch vectors.

Top module: `swcfg_ctrl`

## Requirements
- R1: After power-on reset, all shadow, mask, clock and control registers read 0, and `board_rst`, `cfg_sw`, `clk_cfg_en` and `clk_word_out` are 0.
- R2: A read of any shadow or mask byte, the sequencer control bit or the clock bytes returns the last value written to it. The value is visible on `bus_rdata` in the cycle after the write edge.
- R3: A write of any data to address 0x00 while no reset is active sets `board_rst` at the next edge. The same edge latches the synchronized physical switches onto `cfg_sw`, whatever the mask bits are.
- R4: A write with bit 0 set to address 0x01 starts a sequenced reset only if the stored bit 0 is 0. Writing 1 while the stored bit is already 1 starts nothing, so software writes 0 and then 1.
- R5: A sequenced reset latches the effective value of each bit onto `cfg_sw`: the shadow bit where the mask bit is 1, and the synchronized switch bit where it is 0.
- R6: `board_rst` stays high for exactly RST_HOLD cycles and then goes low.
- R7: A trigger of either kind that arrives while `board_rst` is high is ignored. `cfg_sw` keeps its value and the reset is not lengthened.
- R8: Shadow, mask, clock and control registers keep their values through a board reset.
- R9: `clk_word_out` carries {byte 0x04, byte 0x05, byte 0x06} while bit 0 of 0x02 is 1 and is 0 otherwise. `clk_cfg_en` follows that bit.
- R10: `phys_sw` passes through two flops before use. A switch change made in the same cycle as the trigger write is not captured; the previous value is latched instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| phys_sw | input | 64 | Physical switch inputs, asynchronous |
| cfg_sw | output | 64 | Switch set latched at the last reset trigger |
| board_rst | output | 1 | Board reset, active high |
| clk_cfg_en | output | 1 | Clock word enable |
| clk_word_out | output | 24 | Gated clock frequency word |

## Verification
A register write lands on the clock edge that samples it. Read-back and the gated clock word therefore change right after that edge. `board_rst` and `cfg_sw` also change on that same edge, because the trigger decode feeds the sequencer flops directly. A switch change needs two edges to reach the capture multiplexer. Release falls RST_HOLD edges after the trigger edge. A behavioural model in the bench advances at each rising edge and is compared 3 ns later, well before the falling edge where stimulus changes. Directed checks measure the reset length with a free-running edge counter and stage switch changes relative to trigger writes, covering both the captured and the too-late case.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
   localparam int unsigned SW_GRP_W     = 8;
   localparam int unsigned ADR_HARD_RST = 'h00;
   localparam int unsigned ADR_SEQ_CTL  = 'h01;
   localparam int unsigned ADR_CLK_EN   = 'h02;
   localparam int unsigned ADR_CLK_WORD = 'h04;
   localparam int unsigned ADR_SW_BASE  = 'h10;

   typedef enum logic {
      SRC_RAW = 1'b0,
      SRC_EFF = 1'b1
   } sw_src_e;
endpackage

// File: rtl/swcfg_sync.sv
module swcfg_sync #(
   parameter int unsigned W      = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swcfg_regs.sv
module swcfg_regs
   import swcfg_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CLK_WORD_W = 24
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [SW_GRP_W-1:0]              wdata,
   input  logic [NUM_GROUPS*SW_GRP_W-1:0]   sync_sw,
   output logic [SW_GRP_W-1:0]              rdata,
   output logic [NUM_GROUPS*SW_GRP_W-1:0]   eff_sw,
   output logic                             hard_fire,
   output logic                             seq_fire,
   output logic                             clk_en,
   output logic [CLK_WORD_W-1:0]            clk_word
);
   localparam int unsigned CLK_BYTES = CLK_WORD_W / SW_GRP_W;

   logic [NUM_GROUPS-1:0][SW_GRP_W-1:0] grp_rd;
   logic [CLK_BYTES-1:0][SW_GRP_W-1:0]  clk_rd;
   logic seq_q, clken_q;
   logic hit_hard, hit_seq, hit_cen;

   assign hit_hard = (addr == ADDR_W'(ADR_HARD_RST));
   assign hit_seq  = (addr == ADDR_W'(ADR_SEQ_CTL));
   assign hit_cen  = (addr == ADDR_W'(ADR_CLK_EN));

   assign hard_fire = we && hit_hard;
   assign seq_fire  = we && hit_seq && wdata[0] && !seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q   <= 1'b0;
         clken_q <= 1'b0;
      end else if (we) begin
         if (hit_seq) seq_q   <= wdata[0];
         if (hit_cen) clken_q <= wdata[0];
      end
   end
   assign clk_en = clken_q;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         logic [SW_GRP_W-1:0] shadow_q, mask_q;
         logic hit_sh, hit_mk;
         assign hit_sh = (addr == ADDR_W'(ADR_SW_BASE + 2*g));
         assign hit_mk = (addr == ADDR_W'(ADR_SW_BASE + 2*g + 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               mask_q   <= '0;
            end else if (we) begin
               if (hit_sh) shadow_q <= wdata;
               if (hit_mk) mask_q   <= wdata;
            end
         end
         assign eff_sw[g*SW_GRP_W +: SW_GRP_W] =
            (mask_q & shadow_q) | (~mask_q & sync_sw[g*SW_GRP_W +: SW_GRP_W]);
         assign grp_rd[g] = hit_sh ? shadow_q : (hit_mk ? mask_q : '0);
      end

      for (genvar c = 0; c < CLK_BYTES; c++) begin : g_clk
         logic [SW_GRP_W-1:0] byte_q;
         logic hit_b;
         assign hit_b = (addr == ADDR_W'(ADR_CLK_WORD + c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          byte_q <= '0;
            else if (we && hit_b) byte_q <= wdata;
         end
         assign clk_word[CLK_WORD_W-1-c*SW_GRP_W -: SW_GRP_W] = byte_q;
         assign clk_rd[c] = hit_b ? byte_q : '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) rdata |= grp_rd[g];
      for (int c = 0; c < CLK_BYTES; c++)  rdata |= clk_rd[c];
      if (hit_seq) rdata = {{(SW_GRP_W-1){1'b0}}, seq_q};
      if (hit_cen) rdata = {{(SW_GRP_W-1){1'b0}}, clken_q};
   end
endmodule

// File: rtl/swcfg_rstseq.sv
module swcfg_rstseq
   import swcfg_pkg::*;
#(
   parameter int unsigned W        = 64,
   parameter int unsigned RST_HOLD = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hard_fire,
   input  logic         seq_fire,
   input  logic [W-1:0] raw_sw,
   input  logic [W-1:0] eff_sw,
   output logic         board_rst,
   output logic [W-1:0] cfg_sw
);
   localparam int unsigned CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;

   logic [CNT_W-1:0] cnt_q;
   sw_src_e          src;

   assign src = hard_fire ? SRC_RAW : SRC_EFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         board_rst <= 1'b0;
         cnt_q     <= '0;
         cfg_sw    <= '0;
      end else if (board_rst) begin
         if (cnt_q == '0) board_rst <= 1'b0;
         else             cnt_q     <= cnt_q - 1'b1;
      end else if (hard_fire || seq_fire) begin
         board_rst <= 1'b1;
         cnt_q     <= CNT_W'(RST_HOLD - 1);
         cfg_sw    <= (src == SRC_RAW) ? raw_sw : eff_sw;
      end
   end
endmodule

// File: rtl/swcfg_ctrl.sv
module swcfg_ctrl
   import swcfg_pkg::*;
#(
   parameter int unsigned NUM_GROUPS  = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CLK_WORD_W  = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_HOLD    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_we,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [SW_GRP_W-1:0]            bus_wdata,
   output logic [SW_GRP_W-1:0]            bus_rdata,
   input  logic [NUM_GROUPS*SW_GRP_W-1:0] phys_sw,
   output logic [NUM_GROUPS*SW_GRP_W-1:0] cfg_sw,
   output logic                           board_rst,
   output logic                           clk_cfg_en,
   output logic [CLK_WORD_W-1:0]          clk_word_out
);
   localparam int unsigned SW_W     = NUM_GROUPS * SW_GRP_W;
   localparam int unsigned TOP_ADDR = ADR_SW_BASE + 2*NUM_GROUPS - 1;

   generate
      if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("swcfg_ctrl: ADDR_W too narrow for NUM_GROUPS");
      end
      if ((CLK_WORD_W % SW_GRP_W) != 0 ||
          CLK_WORD_W / SW_GRP_W > ADR_SW_BASE - ADR_CLK_WORD) begin : g_bad_clk
         $error("swcfg_ctrl: CLK_WORD_W must be whole bytes that fit the map");
      end
      if (RST_HOLD < 1 || SYNC_STAGES < 1) begin : g_bad_hold
         $error("swcfg_ctrl: RST_HOLD and SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [SW_W-1:0]       sync_sw, eff_sw;
   logic                  hard_fire, seq_fire, clk_en;
   logic [CLK_WORD_W-1:0] clk_word;

   swcfg_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(phys_sw), .q(sync_sw)
   );

   swcfg_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .CLK_WORD_W(CLK_WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .sync_sw(sync_sw), .rdata(bus_rdata), .eff_sw(eff_sw),
      .hard_fire(hard_fire), .seq_fire(seq_fire), .clk_en(clk_en), .clk_word(clk_word)
   );

   swcfg_rstseq #(.W(SW_W), .RST_HOLD(RST_HOLD)) u_seq (
      .clk(clk), .rst_n(rst_n), .hard_fire(hard_fire), .seq_fire(seq_fire),
      .raw_sw(sync_sw), .eff_sw(eff_sw), .board_rst(board_rst), .cfg_sw(cfg_sw)
   );

   assign clk_cfg_en   = clk_en;
   assign clk_word_out = clk_en ? clk_word : '0;
endmodule

// File: rtl/swcfg_ctrl_chk.sv
module swcfg_ctrl_chk #(
   parameter int unsigned SW_W       = 64,
   parameter int unsigned CLK_WORD_W = 24,
   parameter int unsigned RST_HOLD   = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [SW_W-1:0]       phys_sw,
   input logic [SW_W-1:0]       sync_sw,
   input logic [SW_W-1:0]       eff_sw,
   input logic                  hard_fire,
   input logic                  seq_fire,
   input logic                  board_rst,
   input logic [SW_W-1:0]       cfg_sw,
   input logic                  clk_cfg_en,
   input logic [CLK_WORD_W-1:0] clk_word_out
);
   localparam int unsigned HC_W = $clog2(RST_HOLD + 2);

   logic [HC_W-1:0] hi_cnt;
   logic [1:0]      up_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         up_cnt <= '0;
      end else begin
         hi_cnt <= board_rst ? hi_cnt + 1'b1 : '0;
         if (up_cnt != 2'd2) up_cnt <= up_cnt + 1'b1;
      end
   end

   assert_hard_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_fire && !board_rst) |=> (board_rst && cfg_sw == $past(sync_sw)));

   assert_seq_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_fire && !board_rst) |=> (board_rst && cfg_sw == $past(eff_sw)));

   assert_hold_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      board_rst |-> (hi_cnt < HC_W'(RST_HOLD)));

   assert_hold_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(board_rst) |-> (hi_cnt == HC_W'(RST_HOLD)));

   assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (board_rst && $past(board_rst)) |-> $stable(cfg_sw));

   assert_cfg_only_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_sw) |-> $rose(board_rst));

   assert_clk_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_word_out != '0) |-> clk_cfg_en);

   assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd2) |-> (sync_sw == $past(phys_sw, 2)));
endmodule

bind swcfg_ctrl swcfg_ctrl_chk #(
   .SW_W(NUM_GROUPS*8), .CLK_WORD_W(CLK_WORD_W), .RST_HOLD(RST_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phys_sw(phys_sw), .sync_sw(sync_sw), .eff_sw(eff_sw),
   .hard_fire(hard_fire), .seq_fire(seq_fire), .board_rst(board_rst), .cfg_sw(cfg_sw),
   .clk_cfg_en(clk_cfg_en), .clk_word_out(clk_word_out)
);

// File: tb/swcfg_ctrl_tb.sv
module swcfg_ctrl_tb;
   localparam int NG   = 8;
   localparam int HOLD = 16;

   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, we;
   logic [7:0]  addr, wdata;
   logic [63:0] phys;
   wire  [7:0]  rdata;
   wire  [63:0] cfg;
   wire         brst, cen;
   wire  [23:0] cword;

   int checks = 0, fails = 0, cyc = 0;

   swcfg_ctrl #(.RST_HOLD(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .phys_sw(phys), .cfg_sw(cfg), .board_rst(brst),
      .clk_cfg_en(cen), .clk_word_out(cword)
   );

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0]  m_sw [NG];
   logic [7:0]  m_en [NG];
   logic [7:0]  m_ck [3];
   logic        m_seq, m_cen, m_rst;
   int          m_cnt;
   logic [63:0] p1, p2, m_cfg;

   function automatic logic [7:0] m_read(input logic [7:0] a);
      if (a == 8'h01) return {7'b0, m_seq};
      if (a == 8'h02) return {7'b0, m_cen};
      if (a >= 8'h04 && a <= 8'h06) return m_ck[a - 8'h04];
      if (a >= 8'h10 && a < 8'h10 + 2*NG) begin
         if (a[0]) return m_en[(a - 8'h10) / 2];
         return m_sw[(a - 8'h10) / 2];
      end
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      logic        hard, sq;
      logic [63:0] eff;
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < NG; i++) begin m_sw[i] = 0; m_en[i] = 0; end
         for (int i = 0; i < 3; i++) m_ck[i] = 0;
         m_seq = 0; m_cen = 0; m_rst = 0; m_cnt = 0; p1 = 0; p2 = 0; m_cfg = 0;
      end else begin
         hard = we && addr == 8'h00;
         sq   = we && addr == 8'h01 && wdata[0] && !m_seq;
         for (int i = 0; i < 64; i++)
            eff[i] = m_en[i/8][i%8] ? m_sw[i/8][i%8] : p2[i];
         if (m_rst) begin
            if (m_cnt == 0) m_rst = 0; else m_cnt--;
         end else if (hard || sq) begin
            m_rst = 1; m_cnt = HOLD - 1;
            m_cfg = hard ? p2 : eff;
         end
         if (we) begin
            if (addr == 8'h01) m_seq = wdata[0];
            if (addr == 8'h02) m_cen = wdata[0];
            if (addr >= 8'h04 && addr <= 8'h06) m_ck[addr - 8'h04] = wdata;
            if (addr >= 8'h10 && addr < 8'h10 + 2*NG) begin
               if (addr[0]) m_en[(addr - 8'h10) / 2] = wdata;
               else         m_sw[(addr - 8'h10) / 2] = wdata;
            end
         end
         p2 = p1; p1 = phys;
      end
      #3;
      check("R6", "model board_rst", {63'b0, brst}, {63'b0, m_rst});
      check("R5", "model cfg_sw", cfg, m_cfg);
      check("R9", "model clk_word", {40'b0, cword},
            m_cen ? {40'b0, m_ck[0], m_ck[1], m_ck[2]} : 64'b0);
      check("R2", "model rdata", {56'b0, rdata}, {56'b0, m_read(addr)});
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk); addr = a; #1;
      check(req, "read", {56'b0, rdata}, {56'b0, exp});
   endtask

   task automatic wait_idle();
      while (brst) @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int t0;
      logic [63:0] pa, pb;
      rst_n = 1'b0; we = 1'b0; addr = 8'h00; wdata = 8'h00; phys = 64'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "board_rst", {63'b0, brst}, 64'h0);
      check("R1", "cfg_sw", cfg, 64'h0);
      check("R1", "clk_word", {40'b0, cword}, 64'h0);
      check("R1", "clk_en", {63'b0, cen}, 64'h0);
      rd_chk("R1", 8'h10, 8'h00);
      rd_chk("R1", 8'h1F, 8'h00);

      // R2 read-back
      pa = 64'h0123_4567_89AB_CDA5;
      phys = pa;
      wr(8'h10, 8'hFF); wr(8'h11, 8'h0F); wr(8'h1E, 8'h3C);
      rd_chk("R2", 8'h10, 8'hFF);
      rd_chk("R2", 8'h11, 8'h0F);
      rd_chk("R2", 8'h1E, 8'h3C);

      // R3 hard reset uses raw switches; R6 length
      repeat (3) @(negedge clk);
      wr(8'h00, 8'h00);
      t0 = cyc;
      check("R3", "board_rst set", {63'b0, brst}, 64'h1);
      check("R3", "cfg raw", cfg, pa);
      wait_idle();
      check("R6", "hold cycles", 64'(cyc - t0), 64'(HOLD));

      // R8 persistence
      rd_chk("R8", 8'h10, 8'hFF);
      rd_chk("R8", 8'h11, 8'h0F);

      // R4/R5 sequenced reset with override on group 0
      wr(8'h01, 8'h01);
      check("R4", "seq start", {63'b0, brst}, 64'h1);
      check("R5", "cfg eff", cfg, {pa[63:8], 8'hAF});
      wait_idle();
      rd_chk("R8", 8'h01, 8'h01);
      wr(8'h01, 8'h01);
      repeat (2) @(negedge clk);
      check("R4", "no retrigger", {63'b0, brst}, 64'h0);
      wr(8'h11, 8'hF0);
      wr(8'h01, 8'h00);
      wr(8'h01, 8'h01);
      check("R4", "rearm start", {63'b0, brst}, 64'h1);
      check("R5", "cfg eff 2", cfg, {pa[63:8], 8'hF5});
      wait_idle();

      // R7 trigger while busy ignored
      wr(8'h00, 8'h00);
      t0 = cyc;
      pb = 64'hFEDC_BA98_7654_3210;
      phys = pb;
      repeat (4) @(negedge clk);
      wr(8'h00, 8'h5A);
      check("R7", "cfg unchanged", cfg, pa);
      wait_idle();
      check("R7", "not lengthened", 64'(cyc - t0), 64'(HOLD));

      // R10 late switch change not captured
      @(negedge clk);
      phys = pa; we = 1'b1; addr = 8'h00; wdata = 8'h00;
      @(negedge clk); we = 1'b0;
      check("R10", "old value captured", cfg, pb);
      wait_idle();

      // R9 clock word
      wr(8'h04, 8'h12); wr(8'h05, 8'h34); wr(8'h06, 8'h56);
      check("R9", "gated off", {40'b0, cword}, 64'h0);
      rd_chk("R2", 8'h05, 8'h34);
      wr(8'h02, 8'h01);
      check("R9", "word on", {40'b0, cword}, 64'h123456);
      check("R9", "enable", {63'b0, cen}, 64'h1);
      wr(8'h02, 8'h00);
      check("R9", "word off", {40'b0, cword}, 64'h0);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule